// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block collects up to 224 interrupt sources into seven groups of 32 bits. Each group raises one request line. The sources are 128 general-purpose input pins and two internal events: a timer end-of-count and a cable attach/detach event. Software sets four things per bit through a simple register read/write port:

- whether the bit is edge- or level-sensitive;
- which polarity is active;
- whether the bit is enabled;
- its pending status.

Pins fill the top four groups, starting from the highest group. Inside each group the four byte lanes are reversed, so software must use the pin-to-group/bit formula to find a pin's bit. Some bits can never be enabled:

- every bit of groups 1 and 2;
- the four bits that pins 124–127 occupy;
- every bit of group 0 except the two internal events.

Every source passes through a two-flop synchronizer before edge or level detection. Each group's request is registered. The request of group g drives output line 6 − g, so the groups reach the downstream vectored interrupt controller in reverse order.

Top module: `xint_group_ctrl`

## Requirements
- R1: After reset every polarity, status, enable and type register reads 0, `irq_o` is 0 and `rdata_o` is 0.
- R2: Registers are decoded from the byte address as follows:
  - polarity banks at 0x80, status at 0xA0, enable at 0xC0 and type at 0xE0;
  - group g sits at bank + 4·g, for g from 0 to 6;
  - any other address reads 0.
  A read presents its data on `rdata_o` one clock after `rd_en_i`, and `rdata_o` holds its value while no read is issued. Polarity and type keep whatever value is written.
- R3: Pin n lands in group 6 − (n >> 5), at bit (24 − (n & 24)) | (n & 7). The byte lanes are reversed and the position inside each byte is kept.
- R4: With type bit 0 (edge), the status bit latches on the active transition and stays set after the input returns. Polarity 1 selects the rising edge and polarity 0 the falling edge. The opposite transition sets nothing.
- R5: Writing 1 to an edge-mode status bit clears it. Writing 0 leaves it unchanged.
- R6: With type bit 1 (level), the status bit is 1 exactly while the synchronized input equals the polarity bit, so polarity 1 is active-high and polarity 0 is active-low. Status writes have no effect on it.
- R7: Output line `irq_o[6 − g]` is 1 when group g has any bit set in both status and enable. It is registered, and an enabled bit whose status is 0 raises nothing.
- R8: Every bit of groups 1 and 2, and bits 4–7 of group 3 (the bits of pins 124–127), read 0 in enable and status in both modes, and never raise a request.
- R9: In group 0 only bit 0 (timer end-of-count) and bit 2 (cable event) can be enabled or become pending. The enable register of group 0 reads at most 0x5.
- R10: A pin change reaches the status register on the third rising clock edge after it. The request line follows on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 128 | Asynchronous pin inputs |
| timer_evt_i | input | 1 | Timer end-of-count event, routed to group 0 bit 0 |
| cable_evt_i | input | 1 | Cable attach/detach event, routed to group 0 bit 2 |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one clock after the read strobe |
| irq_o | output | 7 | Request lines, bit 6 − g belongs to group g |

## Verification
The bench builds the block with its default parameters:

- seven groups of 32 bits;
- 128 pins, of which 124 are live;
- the timer and cable events on bits 0 and 2.

With these values every kind of group is reachable: pin groups 6 to 3, the dead groups 1 and 2, and the event group 0. The dead upper pins of group 3 are covered too. Pins 0, 13, 45, 70, 100 and 125 are chosen so that different byte lanes and different groups are exercised. Each request line is observed to confirm the reversed group order.

// File: rtl/xint_pkg.sv
package xint_pkg;

  typedef enum logic [2:0] {
    BANK_POL  = 3'd4,
    BANK_STAT = 3'd5,
    BANK_EN   = 3'd6,
    BANK_TYPE = 3'd7
  } bank_e;

  // byte-lane reversal inside a group word; bit order within a byte is kept
  function automatic int lane_swap(input int b, input int w);
    return ((w / 8 - 1 - b / 8) * 8) + (b % 8);
  endfunction

endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/xint_group.sv
module xint_group #(
  parameter int               GRP_W    = 32,
  parameter logic [GRP_W-1:0] ENA_MASK = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [GRP_W-1:0] src_i,
  input  logic [GRP_W-1:0] wdata_i,
  input  logic             wr_pol_i,
  input  logic             wr_stat_i,
  input  logic             wr_en_i,
  input  logic             wr_type_i,
  output logic [GRP_W-1:0] pol_o,
  output logic [GRP_W-1:0] stat_o,
  output logic [GRP_W-1:0] en_o,
  output logic [GRP_W-1:0] type_o,
  output logic             req_o
);
  logic [GRP_W-1:0] lvl, prev_q;
  logic [GRP_W-1:0] pol_q, stat_q, en_q, type_q;
  logic [GRP_W-1:0] active, evt, clr, stat_nxt;
  logic             req_q;

  xint_sync #(.W(GRP_W)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (src_i),
    .q_o (lvl)
  );

  always_comb begin
    active   = ~(lvl ^ pol_q);
    evt      = (pol_q & lvl & ~prev_q) | (~pol_q & ~lvl & prev_q);
    clr      = wr_stat_i ? wdata_i : '0;
    stat_nxt = (type_q & active) | (~type_q & ((stat_q & ~clr) | evt));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pol_q  <= '0;
      stat_q <= '0;
      en_q   <= '0;
      type_q <= '0;
      req_q  <= 1'b0;
    end else begin
      prev_q <= lvl;
      stat_q <= stat_nxt & ENA_MASK;
      req_q  <= |(stat_q & en_q);
      if (wr_pol_i)  pol_q  <= wdata_i;
      if (wr_en_i)   en_q   <= wdata_i & ENA_MASK;
      if (wr_type_i) type_q <= wdata_i;
    end
  end

  assign pol_o  = pol_q;
  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign type_o = type_q;
  assign req_o  = req_q;

  // R5
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stat_i |=> ((stat_q & $past(wdata_i & ~type_q & ~evt)) == '0));

  // R4
  edge_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_type_i |=> (($past(stat_q & ~type_q & ~clr) & ~stat_q) == '0));

  // R7
  req_source_chk: assert property (@(posedge clk) disable iff (rst)
    req_q |-> $past(|(stat_q & en_q)));

  // R7
  req_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (|(stat_q & en_q)) |=> req_q);
endmodule

// File: rtl/xint_group_ctrl.sv
module xint_group_ctrl #(
  parameter int N_GRP      = 7,
  parameter int GRP_W      = 32,
  parameter int N_PIN      = 128,
  parameter int N_PIN_LIVE = 124,
  parameter int ADDR_W     = 8,
  parameter int TMR_BIT    = 0,
  parameter int CBL_BIT    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PIN-1:0]  pin_i,
  input  logic              timer_evt_i,
  input  logic              cable_evt_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [GRP_W-1:0]  wdata_i,
  output logic [GRP_W-1:0]  rdata_o,
  output logic [N_GRP-1:0]  irq_o
);
  import xint_pkg::*;

  localparam int PIN_GRPS      = N_PIN / GRP_W;
  localparam int FIRST_PIN_GRP = N_GRP - PIN_GRPS;
  localparam int GSEL_LSB      = 2;
  localparam int GSEL_W        = 3;
  localparam int BANK_LSB      = GSEL_LSB + GSEL_W;

  function automatic logic [GRP_W-1:0] grp_mask(input int g);
    logic [GRP_W-1:0] m;
    m = '0;
    if (g == 0) begin
      m[TMR_BIT] = 1'b1;
      m[CBL_BIT] = 1'b1;
    end else if (g >= FIRST_PIN_GRP) begin
      for (int b = 0; b < GRP_W; b++)
        m[b] = ((N_GRP - 1 - g) * GRP_W + lane_swap(b, GRP_W)) < N_PIN_LIVE;
    end
    return m;
  endfunction

  logic [2:0]        bank;
  logic [GSEL_W-1:0] gsel;
  logic [GRP_W-1:0]  pol_v  [N_GRP];
  logic [GRP_W-1:0]  stat_v [N_GRP];
  logic [GRP_W-1:0]  en_v   [N_GRP];
  logic [GRP_W-1:0]  type_v [N_GRP];
  logic [N_GRP-1:0]  req;
  logic [GRP_W-1:0]  rd_val;
  logic [GRP_W-1:0]  rdata_q;

  assign bank = addr_i[BANK_LSB +: 3];
  assign gsel = addr_i[GSEL_LSB +: GSEL_W];

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic [GRP_W-1:0] src;
    logic             hit;

    if (g >= FIRST_PIN_GRP) begin : g_pin
      for (genvar b = 0; b < GRP_W; b++) begin : g_bit
        assign src[b] = pin_i[(N_GRP - 1 - g) * GRP_W + lane_swap(b, GRP_W)];
      end
    end else if (g == 0) begin : g_evt
      always_comb begin
        src          = '0;
        src[TMR_BIT] = timer_evt_i;
        src[CBL_BIT] = cable_evt_i;
      end
    end else begin : g_off
      assign src = '0;
    end

    assign hit = wr_en_i && (gsel == GSEL_W'(g));

    xint_group #(.GRP_W(GRP_W), .ENA_MASK(grp_mask(g))) u_grp (
      .clk       (clk),
      .rst       (rst),
      .src_i     (src),
      .wdata_i   (wdata_i),
      .wr_pol_i  (hit && bank == BANK_POL),
      .wr_stat_i (hit && bank == BANK_STAT),
      .wr_en_i   (hit && bank == BANK_EN),
      .wr_type_i (hit && bank == BANK_TYPE),
      .pol_o     (pol_v[g]),
      .stat_o    (stat_v[g]),
      .en_o      (en_v[g]),
      .type_o    (type_v[g]),
      .req_o     (req[g])
    );

    assign irq_o[N_GRP - 1 - g] = req[g];
  end

  always_comb begin
    rd_val = '0;
    for (int g = 0; g < N_GRP; g++) begin
      if (gsel == GSEL_W'(g)) begin
        case (bank)
          BANK_POL:  rd_val = pol_v[g];
          BANK_STAT: rd_val = stat_v[g];
          BANK_EN:   rd_val = en_v[g];
          BANK_TYPE: rd_val = type_v[g];
          default:   rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/test_xint_group_ctrl.sv
`timescale 1ns/1ps
module test_xint_group_ctrl;
  localparam logic [7:0] A_POL = 8'h80, A_STAT = 8'hA0, A_EN = 8'hC0, A_TYPE = 8'hE0;

  logic         clk = 1'b0;
  logic         rst;
  logic [127:0] pin;
  logic         tmr, cbl, wr_en, rd_en;
  logic [7:0]   addr;
  logic [31:0]  wdata, rdata;
  logic [6:0]   irq;

  int tests = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_pend = 1'b0;

  always #10 clk = ~clk;

  xint_group_ctrl i_xint_group_ctrl (
    .clk(clk), .rst(rst), .pin_i(pin), .timer_evt_i(tmr), .cable_evt_i(cbl),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq));

  function automatic int pgrp(input int n); return 6 - (n >> 5); endfunction
  function automatic int pbit(input int n); return (24 - (n & 24)) | (n & 7); endfunction
  function automatic logic [7:0] ra(input logic [7:0] bank, input int g);
    return bank + 8'(4 * g);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: pushes the expected read value, monitor compares it
  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_n(input int k);
    repeat (k) @(negedge clk);
  endtask

  always @(posedge clk) rd_pend <= rd_en;

  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) chk("scoreboard underflow", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; pin = '0; tmr = 1'b0; cbl = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    wait_n(3);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq after reset", {25'd0, irq}, 32'd0);
    chk("R1 rdata after reset", rdata, 32'd0);
    for (int g = 0; g < 7; g++) begin
      rd(ra(A_POL, g), 0, "R1 polarity");
      rd(ra(A_STAT, g), 0, "R1 status");
      rd(ra(A_EN, g), 0, "R1 enable");
      rd(ra(A_TYPE, g), 0, "R1 type");
    end

    // R2 map and readback
    rd(8'h40, 0, "R2 unmapped address");
    wr(ra(A_POL, 6), 32'hFFFF_FFFF);
    rd(ra(A_POL, 6), 32'hFFFF_FFFF, "R2 polarity g6 readback");
    wr(ra(A_EN, 6), 32'hFFFF_FFFF);
    rd(ra(A_EN, 6), 32'hFFFF_FFFF, "R2 enable g6 readback");
    wr(ra(A_TYPE, 2), 32'h0F0F_1234);
    rd(ra(A_TYPE, 2), 32'h0F0F_1234, "R2 type g2 readback");

    // R10 latency, R3 mapping, R7 line order (pin 0 -> g6 bit 24 -> line 0)
    pin[0] = 1'b1;
    wait_n(2);
    rd(ra(A_STAT, pgrp(0)), 0, "R10 status before third edge");
    chk("R10 irq not yet", {31'd0, irq[0]}, 32'd0);
    rd(ra(A_STAT, pgrp(0)), 32'd1 << pbit(0), "R10 status on third edge");
    chk("R7 R10 irq line 0", {31'd0, irq[0]}, 32'd1);

    // R4 sticky, R5 clear
    pin[0] = 1'b0;
    wait_n(4);
    rd(ra(A_STAT, 6), 32'd1 << 24, "R4 edge stays after release");
    wr(ra(A_STAT, 6), 32'd0);
    rd(ra(A_STAT, 6), 32'd1 << 24, "R5 zero write keeps bit");
    wr(ra(A_STAT, 6), 32'd1 << 24);
    wait_n(1);
    chk("R5 R7 irq drops after clear", {31'd0, irq[0]}, 32'd0);
    rd(ra(A_STAT, 6), 0, "R5 one write clears");

    // R3 lane reversal: pin 13 -> bit 21
    pin[13] = 1'b1;
    wait_n(4);
    rd(ra(A_STAT, pgrp(13)), 32'd1 << pbit(13), "R3 pin 13 lane reversal");
    wr(ra(A_STAT, 6), 32'hFFFF_FFFF);
    pin[13] = 1'b0;

    // R4 falling polarity on pin 45 (g5 bit 21), R7 enable gating on line 1
    pin[45] = 1'b1;
    wait_n(4);
    rd(ra(A_STAT, pgrp(45)), 0, "R4 rising ignored with polarity 0");
    pin[45] = 1'b0;
    wait_n(4);
    rd(ra(A_STAT, 5), 32'd1 << pbit(45), "R4 falling edge latched");
    chk("R7 disabled bit raises nothing", {31'd0, irq[1]}, 32'd0);
    wr(ra(A_EN, 5), 32'd1 << 21);
    wait_n(1);
    chk("R7 irq line 1 for group 5", {31'd0, irq[1]}, 32'd1);
    wr(ra(A_STAT, 5), 32'd1 << 21);
    wait_n(1);
    chk("R7 line 1 drops", {31'd0, irq[1]}, 32'd0);

    // R6 level mode on group 4, pin 70 -> bit 30
    wr(ra(A_POL, 4), 32'hFFFF_FFFF);
    wr(ra(A_TYPE, 4), 32'hFFFF_FFFF);
    pin[70] = 1'b1;
    wait_n(4);
    rd(ra(A_STAT, pgrp(70)), 32'd1 << pbit(70), "R6 active-high level");
    wr(ra(A_STAT, 4), 32'hFFFF_FFFF);
    rd(ra(A_STAT, 4), 32'd1 << 30, "R6 status write ignored");
    pin[70] = 1'b0;
    wait_n(4);
    rd(ra(A_STAT, 4), 0, "R6 level gone");
    wr(ra(A_POL, 4), 32'd0);
    wait_n(2);
    rd(ra(A_STAT, 4), 32'hFFFF_FFFF, "R6 active-low level");
    wr(ra(A_POL, 4), 32'hFFFF_FFFF);
    wait_n(2);
    wr(ra(A_TYPE, 4), 32'd0);

    // R8 hardwired bits
    wr(ra(A_EN, 1), 32'hFFFF_FFFF);
    rd(ra(A_EN, 1), 0, "R8 group 1 enable reads 0");
    wr(ra(A_EN, 2), 32'hFFFF_FFFF);
    rd(ra(A_EN, 2), 0, "R8 group 2 enable reads 0");
    wr(ra(A_TYPE, 1), 32'hFFFF_FFFF);
    wait_n(3);
    rd(ra(A_STAT, 1), 0, "R8 group 1 level-low stays 0");
    wr(ra(A_POL, 3), 32'hFFFF_FFFF);
    wr(ra(A_EN, 3), 32'hFFFF_FFFF);
    rd(ra(A_EN, 3), 32'hFFFF_FF0F, "R8 group 3 enable mask");
    pin[125] = 1'b1;
    pin[100] = 1'b1;
    wait_n(4);
    rd(ra(A_STAT, 3), 32'd1 << pbit(100), "R8 pin 125 masked, pin 100 live");
    chk("R7 irq line 3 for group 3", {31'd0, irq[3]}, 32'd1);
    chk("R8 lines of groups 1 and 2 silent", {30'd0, irq[5:4]}, 32'd0);

    // R9 group 0 events
    wr(ra(A_EN, 0), 32'hFFFF_FFFF);
    rd(ra(A_EN, 0), 32'h5, "R9 group 0 enable mask");
    wr(ra(A_POL, 0), 32'h5);
    tmr = 1'b1;
    wait_n(1);
    tmr = 1'b0;
    wait_n(4);
    rd(ra(A_STAT, 0), 32'h1, "R9 timer event on bit 0");
    chk("R9 irq line 6 for group 0", {31'd0, irq[6]}, 32'd1);
    cbl = 1'b1;
    wait_n(1);
    cbl = 1'b0;
    wait_n(4);
    rd(ra(A_STAT, 0), 32'h5, "R9 cable event on bit 2");
    wr(ra(A_STAT, 0), 32'h5);
    wait_n(1);
    chk("R9 line 6 drops after clear", {31'd0, irq[6]}, 32'd0);

    // R2 read data held without a read
    rd(ra(A_EN, 0), 32'h5, "R2 read before hold");
    wait_n(3);
    chk("R2 rdata held", rdata, 32'h5);

    wait_n(2);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule